// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a 32-bit RISC-V conditional branch in one step. It receives the address of the instruction, the instruction word itself and the two source operand values. It rebuilds the branch offset from the pieces of the instruction word where that offset is stored, and adds it to the instruction's own address to form the destination. It compares the operands in the way the instruction's condition field asks for, and then picks the next fetch address: the destination if the condition holds, or the following instruction if it does not.

The destination, the raw comparison outcome and the selected next address are separate outputs, so each can be traced on its own. Two flags report condition codes that are not defined and taken branches that land on an address that is not 4-byte aligned. By default all outputs are registered, which gives one cycle of latency. A parameter can make the whole path combinational instead. Other parameters choose between two separate comparators and one shared subtractor, and can switch off the alignment check for cores that also run 16-bit instructions.

Top module: `brres_unit`

## Requirements
- R1: The offset is rebuilt as off[12]=inst[31], off[11]=inst[7], off[10:5]=inst[30:25], off[4:1]=inst[11:8] and off[0]=0. It is sign-extended from bit 12, and `target_o` equals the instruction address plus this offset, never the address plus 4.
- R2: Negative offsets, down to -4096, produce destinations below the instruction address.
- R3: Condition code 000 is true when the operands are equal, and code 001 is true when they differ.
- R4: Code 100 is a two's-complement less-than and code 101 is its complement, two's-complement greater-or-equal.
- R5: Code 110 is an unsigned less-than and code 111 is an unsigned greater-or-equal. For 0xFFFFFFFF against 0x00000001, the unsigned pair and the signed pair give opposite results.
- R6: A branch is taken only when the condition holds. `next_pc_o` is then `target_o`; otherwise it is the instruction address plus 4.
- R7: With the branch opcode 1100011, codes 010 and 011 raise `illegal_o`, never take, select address plus 4 and give `cond_o`=0.
- R8: When `br_valid` is low, or bits [6:0] of the instruction are not 1100011, nothing is taken, `illegal_o` stays low and `next_pc_o` is the address plus 4.
- R9: `misalign_o` is raised only for a taken branch whose destination has bit 1 set. With the compressed option enabled it stays low.
- R10: With registered outputs, each result appears at the clock edge after its inputs. `out_valid_o` repeats `br_valid`, and reset clears every output to zero.
- R11: `target_o` and `cond_o` report the destination and the comparison for the decoded code whether or not the branch is taken or valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Instruction word is present and may be acted on |
| pc_in | input | 32 | Address of the instruction |
| inst_in | input | 32 | Raw instruction word |
| rs1_val | input | 32 | First operand value |
| rs2_val | input | 32 | Second operand value |
| taken_o | output | 1 | Branch is taken |
| cond_o | output | 1 | Raw comparison outcome for the decoded code |
| illegal_o | output | 1 | Branch opcode carrying an undefined condition code |
| misalign_o | output | 1 | Taken destination not 4-byte aligned |
| out_valid_o | output | 1 | Outputs belong to a valid input |
| target_o | output | 32 | Computed branch destination |
| next_pc_o | output | 32 | Selected next fetch address |

## Verification
The bench builds the block twice and drives both with the same inputs. The first build uses the defaults: registered outputs, two separate comparators and the alignment check active. It covers the one-cycle latency, the reset values and the misaligned flag. The second build is combinational, uses the shared subtractor and enables the compressed option. It has to give the same taken, destination and next-address results as the first while never raising `misalign_o`, which shows that the two comparator structures agree at the signed/unsigned boundary operands.

// File: rtl/brres_pkg.sv
package brres_pkg;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam int unsigned OFF_W = 13;

   typedef enum logic [2:0] {
      CC_EQ   = 3'b000,
      CC_NE   = 3'b001,
      CC_RSV2 = 3'b010,
      CC_RSV3 = 3'b011,
      CC_LT   = 3'b100,
      CC_GE   = 3'b101,
      CC_LTU  = 3'b110,
      CC_GEU  = 3'b111
   } br_cc_e;

   typedef struct packed {
      logic valid;
      logic taken;
      logic cond;
      logic illegal;
      logic misalign;
   } br_flags_t;
endpackage

// File: rtl/brres_offgen.sv
module brres_offgen
   import brres_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [6:0]      hi_bits,   // instruction bits 31:25
   input  logic [4:0]      lo_bits,   // instruction bits 11:7
   output logic [XLEN-1:0] offset
);
   localparam int unsigned EXT_W = XLEN - OFF_W;

   logic [OFF_W-1:0] raw;

   always_comb begin
      raw[12]   = hi_bits[6];
      raw[11]   = lo_bits[0];
      raw[10:5] = hi_bits[5:0];
      raw[4:1]  = lo_bits[4:1];
      raw[0]    = 1'b0;
   end

   assign offset = {{EXT_W{raw[OFF_W-1]}}, raw};
endmodule

// File: rtl/brres_cmp.sv
module brres_cmp
   import brres_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          CMP_SHARED = 1'b0
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic [2:0]      cc,
   output logic            cond,
   output logic            bad_cc
);
   localparam int unsigned MSB = XLEN - 1;

   logic is_eq, is_lt_s, is_lt_u;

   assign is_eq = (op_a == op_b);

   generate
      if (CMP_SHARED) begin : g_shared
         logic [XLEN:0] diff;
         assign diff    = {1'b0, op_a} - {1'b0, op_b};
         assign is_lt_u = diff[XLEN];
         assign is_lt_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : diff[XLEN];
      end else begin : g_split
         assign is_lt_u = (op_a < op_b);
         assign is_lt_s = ($signed(op_a) < $signed(op_b));
         always_comb begin
            if (op_a[MSB] == op_b[MSB])
               AST_SIGN_AGREE: assert (is_lt_s == is_lt_u); // R5
         end
      end
   endgenerate

   always_comb begin
      cond   = 1'b0;
      bad_cc = 1'b0;
      unique case (br_cc_e'(cc))
         CC_EQ:   cond = is_eq;
         CC_NE:   cond = !is_eq;
         CC_LT:   cond = is_lt_s;
         CC_GE:   cond = !is_lt_s;
         CC_LTU:  cond = is_lt_u;
         CC_GEU:  cond = !is_lt_u;
         CC_RSV2,
         CC_RSV3: bad_cc = 1'b1;
      endcase
   end
endmodule

// File: rtl/brres_target.sv
module brres_target #(
   parameter int unsigned XLEN      = 32,
   parameter bit          ALLOW_C   = 1'b0,
   parameter int unsigned INST_BYTES = 4
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] offset,
   input  logic            take,
   output logic [XLEN-1:0] target,
   output logic [XLEN-1:0] next_pc,
   output logic            misalign
);
   logic [XLEN-1:0] fall;

   assign target  = pc + offset;
   assign fall    = pc + XLEN'(INST_BYTES);
   assign next_pc = take ? target : fall;

   generate
      if (ALLOW_C) begin : g_half_ok
         assign misalign = 1'b0;
      end else begin : g_word_only
         assign misalign = take & target[1];
      end
   endgenerate
endmodule

// File: rtl/brres_unit.sv
module brres_unit
   import brres_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          CMP_SHARED = 1'b0,
   parameter bit          ALLOW_C    = 1'b0,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_valid,
   input  logic [31:0]     pc_in,
   input  logic [31:0]     inst_in,
   input  logic [31:0]     rs1_val,
   input  logic [31:0]     rs2_val,
   output logic            taken_o,
   output logic            cond_o,
   output logic            illegal_o,
   output logic            misalign_o,
   output logic            out_valid_o,
   output logic [31:0]     target_o,
   output logic [31:0]     next_pc_o
);
   initial begin
      AST_PARAM_XLEN: assert (XLEN == 32) else $error("XLEN must be 32"); // R1
   end

   logic [XLEN-1:0] offset, target, next_pc;
   logic            cond, bad_cc, is_branch, take, illegal, misalign;
   logic            unused_fields;
   br_flags_t       flags;

   assign unused_fields = ^inst_in[24:15];
   assign is_branch     = br_valid && (inst_in[6:0] == OPC_BRANCH);

   brres_offgen #(.XLEN(XLEN)) u_off (
      .hi_bits (inst_in[31:25]),
      .lo_bits (inst_in[11:7]),
      .offset  (offset)
   );

   brres_cmp #(.XLEN(XLEN), .CMP_SHARED(CMP_SHARED)) u_cmp (
      .op_a   (rs1_val),
      .op_b   (rs2_val),
      .cc     (inst_in[14:12]),
      .cond   (cond),
      .bad_cc (bad_cc)
   );

   assign illegal = is_branch && bad_cc;
   assign take    = is_branch && !bad_cc && cond;

   brres_target #(.XLEN(XLEN), .ALLOW_C(ALLOW_C)) u_tgt (
      .pc       (pc_in),
      .offset   (offset),
      .take     (take),
      .target   (target),
      .next_pc  (next_pc),
      .misalign (misalign)
   );

   always_comb begin
      flags.valid    = br_valid;
      flags.taken    = take;
      flags.cond     = cond;
      flags.illegal  = illegal;
      flags.misalign = misalign;
   end

   generate
      if (REG_OUT) begin : g_reg
         br_flags_t       flags_q;
         logic [XLEN-1:0] target_q, next_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags_q  <= '0;
               target_q <= '0;
               next_q   <= '0;
            end else begin
               flags_q  <= flags;
               target_q <= target;
               next_q   <= next_pc;
            end
         end
         assign out_valid_o = flags_q.valid;
         assign taken_o     = flags_q.taken;
         assign cond_o      = flags_q.cond;
         assign illegal_o   = flags_q.illegal;
         assign misalign_o  = flags_q.misalign;
         assign target_o    = target_q;
         assign next_pc_o   = next_q;

         AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && !taken_o) |-> (next_pc_o == $past(pc_in) + 32'd4)); // R6
      end else begin : g_comb
         assign out_valid_o = flags.valid;
         assign taken_o     = flags.taken;
         assign cond_o      = flags.cond;
         assign illegal_o   = flags.illegal;
         assign misalign_o  = flags.misalign;
         assign target_o    = target;
         assign next_pc_o   = next_pc;
      end
   endgenerate

   AST_TAKEN_SELECTS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> (next_pc_o == target_o)); // R6
   AST_TAKEN_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> cond_o); // R6
   AST_ILLEGAL_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !taken_o); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> (!taken_o && !illegal_o)); // R8
   AST_MISALIGN_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (taken_o && target_o[1])); // R9
endmodule

// File: tb/tb_brres_unit.sv
module tb_brres_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid = 1'b0;
   logic [31:0] pc_in = '0, inst_in = '0, rs1_val = '0, rs2_val = '0;

   logic        taken_o, cond_o, illegal_o, misalign_o, out_valid_o;
   logic [31:0] target_o, next_pc_o;
   logic        a_taken, a_cond, a_illegal, a_misalign, a_valid;
   logic [31:0] a_target, a_next;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   brres_unit dut (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .pc_in(pc_in),
      .inst_in(inst_in), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .taken_o(taken_o), .cond_o(cond_o), .illegal_o(illegal_o),
      .misalign_o(misalign_o), .out_valid_o(out_valid_o),
      .target_o(target_o), .next_pc_o(next_pc_o)
   );

   brres_unit #(.CMP_SHARED(1'b1), .ALLOW_C(1'b1), .REG_OUT(1'b0)) dut_alt (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .pc_in(pc_in),
      .inst_in(inst_in), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .taken_o(a_taken), .cond_o(a_cond), .illegal_o(a_illegal),
      .misalign_o(a_misalign), .out_valid_o(a_valid),
      .target_o(a_target), .next_pc_o(a_next)
   );

   function automatic logic [31:0] enc(input int off, input logic [2:0] cc,
                                       input logic [6:0] opc);
      logic [12:0] o;
      o = off[12:0];
      return {o[12], o[10:5], 5'd2, 5'd1, cc, o[4:1], o[11], opc};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, then wait one full cycle to the next falling edge
   task automatic drive(input logic v, input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
      br_valid = v; pc_in = pc; inst_in = ins; rs1_val = a; rs2_val = b;
      @(negedge clk);
   endtask

   task automatic expect_all(input string req, input logic et, input logic [31:0] etgt,
                             input logic [31:0] enext, input logic ec,
                             input logic eill, input logic emis);
      chk(req, "taken", 32'(taken_o), 32'(et));
      chk(req, "target", target_o, etgt);
      chk(req, "next_pc", next_pc_o, enext);
      chk(req, "cond", 32'(cond_o), 32'(ec));
      chk(req, "illegal", 32'(illegal_o), 32'(eill));
      chk(req, "misalign", 32'(misalign_o), 32'(emis));
      chk(req, "alt taken", 32'(a_taken), 32'(et));
      chk(req, "alt cond", 32'(a_cond), 32'(ec));
      chk(req, "alt next_pc", a_next, enext);
      chk(req, "alt target", a_target, etgt);
      chk(req, "alt illegal", 32'(a_illegal), 32'(eill));
      chk("R9", "alt misalign", 32'(a_misalign), 32'd0);
   endtask

   task automatic t_reset;   // R10
      chk("R10", "reset taken", 32'(taken_o), 32'd0);
      chk("R10", "reset valid", 32'(out_valid_o), 32'd0);
      chk("R10", "reset target", target_o, 32'd0);
      chk("R10", "reset next_pc", next_pc_o, 32'd0);
      chk("R10", "reset flags", {28'd0, cond_o, illegal_o, misalign_o, 1'b0}, 32'd0);
   endtask

   task automatic t_forward;   // R1, R11
      drive(1, 32'h0000_1000, enc(36, 3'b000, 7'b1100011), 32'd7, 32'd7);
      expect_all("R1", 1, 32'h0000_1024, 32'h0000_1024, 1, 0, 0);
      chk("R10", "valid", 32'(out_valid_o), 32'd1);
      drive(1, 32'h0000_2000, enc(32'h0AAA, 3'b001, 7'b1100011), 32'd5, 32'd5);
      expect_all("R11", 0, 32'h0000_2AAA, 32'h0000_2004, 0, 0, 0);
      drive(1, 32'h0000_0040, enc(4094, 3'b000, 7'b1100011), 32'd1, 32'd2);
      expect_all("R1", 0, 32'h0000_103E, 32'h0000_0044, 0, 0, 0);
   endtask

   task automatic t_backward;   // R2
      drive(1, 32'h0000_3000, enc(-8, 3'b001, 7'b1100011), 32'd1, 32'd2);
      expect_all("R2", 1, 32'h0000_2FF8, 32'h0000_2FF8, 1, 0, 0);
      drive(1, 32'h0000_3000, enc(-4096, 3'b001, 7'b1100011), 32'd1, 32'd2);
      expect_all("R2", 1, 32'h0000_2000, 32'h0000_2000, 1, 0, 0);
      drive(1, 32'h0000_0010, enc(-32, 3'b001, 7'b1100011), 32'd1, 32'd2);
      expect_all("R2", 1, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 1, 0, 0);
   endtask

   task automatic t_equality;   // R3
      drive(1, 32'h100, enc(16, 3'b000, 7'b1100011), 32'h8000_0000, 32'h8000_0001);
      expect_all("R3", 0, 32'h110, 32'h104, 0, 0, 0);
      drive(1, 32'h100, enc(16, 3'b001, 7'b1100011), 32'h8000_0000, 32'h8000_0001);
      expect_all("R3", 1, 32'h110, 32'h110, 1, 0, 0);
      drive(1, 32'h100, enc(16, 3'b001, 7'b1100011), 32'hDEAD_BEEF, 32'hDEAD_BEEF);
      expect_all("R3", 0, 32'h110, 32'h104, 0, 0, 0);
   endtask

   task automatic t_signed;   // R4
      drive(1, 32'h200, enc(-16, 3'b100, 7'b1100011), 32'hFFFF_FFFF, 32'h1);
      expect_all("R4", 1, 32'h1F0, 32'h1F0, 1, 0, 0);
      drive(1, 32'h200, enc(-16, 3'b101, 7'b1100011), 32'hFFFF_FFFF, 32'h1);
      expect_all("R4", 0, 32'h1F0, 32'h204, 0, 0, 0);
      drive(1, 32'h200, enc(-16, 3'b100, 7'b1100011), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      expect_all("R4", 0, 32'h1F0, 32'h204, 0, 0, 0);
      drive(1, 32'h200, enc(-16, 3'b101, 7'b1100011), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      expect_all("R4", 1, 32'h1F0, 32'h1F0, 1, 0, 0);
      drive(1, 32'h200, enc(-16, 3'b101, 7'b1100011), 32'h7FFF_FFFF, 32'h8000_0000);
      expect_all("R4", 1, 32'h1F0, 32'h1F0, 1, 0, 0);
   endtask

   task automatic t_unsigned;   // R5
      drive(1, 32'h300, enc(8, 3'b110, 7'b1100011), 32'hFFFF_FFFF, 32'h1);
      expect_all("R5", 0, 32'h308, 32'h304, 0, 0, 0);
      drive(1, 32'h300, enc(8, 3'b111, 7'b1100011), 32'hFFFF_FFFF, 32'h1);
      expect_all("R5", 1, 32'h308, 32'h308, 1, 0, 0);
      drive(1, 32'h300, enc(8, 3'b110, 7'b1100011), 32'h7FFF_FFFF, 32'h8000_0000);
      expect_all("R5", 1, 32'h308, 32'h308, 1, 0, 0);
      drive(1, 32'h300, enc(8, 3'b111, 7'b1100011), 32'h5, 32'h5);
      expect_all("R5", 1, 32'h308, 32'h308, 1, 0, 0);
   endtask

   task automatic t_illegal;   // R7, R6
      drive(1, 32'h400, enc(64, 3'b010, 7'b1100011), 32'h3, 32'h3);
      expect_all("R7", 0, 32'h440, 32'h404, 0, 1, 0);
      drive(1, 32'h400, enc(64, 3'b011, 7'b1100011), 32'h3, 32'h9);
      expect_all("R7", 0, 32'h440, 32'h404, 0, 1, 0);
   endtask

   task automatic t_gating;   // R8, R11
      drive(0, 32'h500, enc(12, 3'b000, 7'b1100011), 32'h4, 32'h4);
      expect_all("R8", 0, 32'h50C, 32'h504, 1, 0, 0);
      chk("R8", "valid low", 32'(out_valid_o), 32'd0);
      drive(1, 32'h500, enc(12, 3'b000, 7'b0010011), 32'h4, 32'h4);
      expect_all("R8", 0, 32'h50C, 32'h504, 1, 0, 0);
      drive(1, 32'h500, enc(12, 3'b010, 7'b0110011), 32'h4, 32'h4);
      expect_all("R8", 0, 32'h50C, 32'h504, 0, 0, 0);
   endtask

   task automatic t_misalign;   // R9
      drive(1, 32'h100, enc(6, 3'b000, 7'b1100011), 32'h1, 32'h1);
      expect_all("R9", 1, 32'h106, 32'h106, 1, 0, 1);
      drive(1, 32'h100, enc(6, 3'b001, 7'b1100011), 32'h1, 32'h1);
      expect_all("R9", 0, 32'h106, 32'h104, 0, 0, 0);
      drive(1, 32'h102, enc(-2, 3'b000, 7'b1100011), 32'h1, 32'h1);
      expect_all("R9", 1, 32'h100, 32'h100, 1, 0, 0);
   endtask

   task automatic t_latency;   // R10
      drive(1, 32'h600, enc(20, 3'b000, 7'b1100011), 32'h1, 32'h1);
      br_valid = 1'b1; pc_in = 32'h700; inst_in = enc(20, 3'b001, 7'b1100011);
      rs1_val = 32'h1; rs2_val = 32'h1;
      #1;
      chk("R10", "held next_pc", next_pc_o, 32'h614);
      chk("R10", "held taken", 32'(taken_o), 32'd1);
      chk("R10", "alt immediate next_pc", a_next, 32'h704);
      @(negedge clk);
      chk("R10", "updated next_pc", next_pc_o, 32'h704);
      chk("R10", "updated taken", 32'(taken_o), 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_forward();
      t_backward();
      t_equality();
      t_signed();
      t_unsigned();
      t_illegal();
      t_gating();
      t_misalign();
      t_latency();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule